// File: doc/BRIEF.md
# Illegal-Opcode Exception Entry Sequencer

This block moves a CPU core from normal execution into its illegal-opcode handler. When the decoder reports an undefined opcode with a one-cycle trigger, the sequencer captures the program counter, the condition-code byte, the extended control byte and the stack pointer. It then pushes three 16-bit words onto a pre-decrementing stack through a word-wide write port. It raises the interrupt mask and clears the trace flag, with the priority-mask change depending on the selected interrupt control mode. Last, it fetches the handler address from a fixed vector slot through a read port with one cycle of latency.

The new PC, CCR, EXR and SP values come out together with a one-cycle done pulse, so the core can capture them. Triggering is never masked. A trigger that arrives while the sequencer is busy is ignored. Decoding, pipeline control and other exception sources belong to other blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: In any idle cycle, a high `trig_i` at a rising clock edge starts the sequence and samples `pc_i`, `ccr_i`, `exr_i`, `sp_i` and `icm2_i`. `busy_o` is high from the next cycle onward.
- R2: Three single-cycle writes follow in cycles 1, 2 and 3 after the trigger edge. They go to SP-2 with data PC[15:0], then to SP-4 with data {CCR, PC[23:16]} (CCR in bits 15:8), then to SP-6 with data {EXR, 8'h00}.
- R3: The SP delivered with done equals the sampled SP minus 6.
- R4: The delivered CCR has bit 7 (interrupt mask) set to 1. All other CCR bits, including bit 6 (user bit), keep their sampled values.
- R5: The delivered EXR has bit 7 (trace) cleared to 0 in both modes.
- R6: With `icm2_i`=1 (mode 2), EXR bits 2:0 (priority mask) become 3'b111. With `icm2_i`=0 (mode 0), EXR bits 6:0 keep their sampled values.
- R7: Reads of `VEC_ADDR` and `VEC_ADDR`+2 are issued in cycles 5 and 6. Read data arrives one cycle after its request. The new PC is {upper word[7:0], lower word}.
- R8: `busy_o` stays high through the done cycle and is low in the cycle after it. Triggers that arrive while busy are ignored.
- R9: `done_o` is a single-cycle pulse in cycle 8 after the trigger edge. In that cycle `pc_o`, `ccr_o`, `exr_o` and `sp_o` already carry the new values, and they hold those values afterwards.
- R10: During reset, busy, done and both enables are low and all four result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Undefined-opcode trigger |
| icm2_i | input | 1 | 1 selects interrupt control mode 2, 0 selects mode 0 |
| pc_i | input | 24 | Current program counter |
| ccr_i | input | 8 | Current condition-code byte |
| exr_i | input | 8 | Current extended control byte |
| sp_i | input | 24 | Current stack pointer |
| wr_en_o | output | 1 | Stack write strobe |
| wr_addr_o | output | 24 | Stack write address |
| wr_data_o | output | 16 | Stack write data |
| rd_en_o | output | 1 | Vector read strobe |
| rd_addr_o | output | 24 | Vector read address |
| rd_data_i | input | 16 | Read data, valid one cycle after the strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pc_o | output | 24 | Handler PC |
| ccr_o | output | 8 | Updated condition-code byte |
| exr_o | output | 8 | Updated extended control byte |
| sp_o | output | 24 | Updated stack pointer |

## Verification
All timing is counted from the trigger edge, which is edge 0. The writes are due in cycles 1 to 3 and the vector reads in cycles 5 and 6. Done and the new state are due in cycle 8, and busy is low again from cycle 9. The bench keeps a behavioural step counter that advances on each rising edge, the same way. It derives the expected strobes, addresses, data and results from that step, and it compares every output on the falling edge of every cycle, so each result is checked in exactly the cycle it is due.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   typedef enum logic [3:0] {
      ST_IDLE  = 4'd0,
      ST_PUSH0 = 4'd1,
      ST_PUSH1 = 4'd2,
      ST_PUSH2 = 4'd3,
      ST_MASK  = 4'd4,
      ST_RDHI  = 4'd5,
      ST_RDLO  = 4'd6,
      ST_LOAD  = 4'd7,
      ST_FIN   = 4'd8
   } seq_state_e;

   localparam int CTL_W = 8;
   localparam int TRACE_BIT = 7;
   localparam int IMASK_BIT = 7;
endpackage

// File: rtl/exc_push_fmt.sv
module exc_push_fmt #(
   parameter int AW   = 24,
   parameter int DW   = 16,
   parameter int PC_W = 24
) (
   input  logic [1:0]      step_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [7:0]      ccr_i,
   input  logic [7:0]      exr_i,
   input  logic [AW-1:0]   sp_i,
   output logic [AW-1:0]   addr_o,
   output logic [DW-1:0]   data_o
);
   localparam int HI_W = PC_W - 16;

   logic [7:0] pc_hi;

   generate
      if (HI_W >= 8) begin : g_full_hi
         assign pc_hi = pc_i[23:16];
      end else begin : g_part_hi
         assign pc_hi = {{(8-HI_W){1'b0}}, pc_i[PC_W-1:16]};
      end
   endgenerate

   always_comb begin
      addr_o = sp_i - AW'({step_i, 1'b0}) - AW'(2);
      case (step_i)
         2'd0:    data_o = DW'(pc_i[15:0]);
         2'd1:    data_o = DW'({ccr_i, pc_hi});
         default: data_o = DW'({exr_i, 8'h00});
      endcase
   end
endmodule

// File: rtl/exc_mask_upd.sv
module exc_mask_upd
   import exc_entry_pkg::*;
#(
   parameter int PRIO_W = 3
) (
   input  logic             icm2_i,
   input  logic [CTL_W-1:0] ccr_i,
   input  logic [CTL_W-1:0] exr_i,
   output logic [CTL_W-1:0] ccr_o,
   output logic [CTL_W-1:0] exr_o
);
   always_comb begin
      ccr_o = ccr_i;
      ccr_o[IMASK_BIT] = 1'b1;
      exr_o = exr_i;
      exr_o[TRACE_BIT] = 1'b0;
      if (icm2_i) exr_o[PRIO_W-1:0] = '1;
   end
endmodule

// File: rtl/exc_vec_join.sv
module exc_vec_join #(
   parameter int DW   = 16,
   parameter int PC_W = 24
) (
   input  logic [DW-1:0]   hi_i,
   input  logic [DW-1:0]   lo_i,
   output logic [PC_W-1:0] pc_o
);
   localparam int FULL_W = 2 * DW;

   generate
      if (PC_W < FULL_W) begin : g_trunc
         assign pc_o = {hi_i[PC_W-DW-1:0], lo_i};
      end else begin : g_whole
         assign pc_o = {hi_i, lo_i};
      end
   endgenerate
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_entry_pkg::*;
#(
   parameter int          AW       = 24,
   parameter int          DW       = 16,
   parameter int          PC_W     = 24,
   parameter int          PRIO_W   = 3,
   parameter logic [23:0] VEC_ADDR = 24'h000010
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            trig_i,
   input  logic            icm2_i,
   input  logic [23:0]     pc_i,
   input  logic [7:0]      ccr_i,
   input  logic [7:0]      exr_i,
   input  logic [23:0]     sp_i,
   output logic            wr_en_o,
   output logic [23:0]     wr_addr_o,
   output logic [15:0]     wr_data_o,
   output logic            rd_en_o,
   output logic [23:0]     rd_addr_o,
   input  logic [15:0]     rd_data_i,
   output logic            busy_o,
   output logic            done_o,
   output logic [23:0]     pc_o,
   output logic [7:0]      ccr_o,
   output logic [7:0]      exr_o,
   output logic [23:0]     sp_o
);
   localparam int          PUSH_WORDS = 3;
   localparam logic [AW-1:0] SP_DROP  = AW'(2 * PUSH_WORDS);
   localparam logic [AW-1:0] VEC_LO   = AW'(VEC_ADDR) + AW'(2);

   initial begin
      assert (DW == 16) else $error("word width must be 16");
      assert (AW == 24 && PC_W > 16 && PC_W <= 24) else $error("address or PC width out of range");
      assert (PRIO_W > 0 && PRIO_W < 7) else $error("priority mask width out of range");
   end

   seq_state_e       st_q;
   logic [PC_W-1:0]  pc_s;
   logic [7:0]       ccr_s, exr_s;
   logic [AW-1:0]    sp_s;
   logic             icm_s;
   logic [DW-1:0]    vhi_q;
   logic [PC_W-1:0]  pc_q;
   logic [7:0]       ccr_q, exr_q;
   logic [AW-1:0]    sp_q;

   logic [1:0]       push_step;
   logic [AW-1:0]    push_addr;
   logic [DW-1:0]    push_data;
   logic [7:0]       ccr_nx, exr_nx;
   logic [PC_W-1:0]  vec_pc;

   always_comb begin
      case (st_q)
         ST_PUSH1: push_step = 2'd1;
         ST_PUSH2: push_step = 2'd2;
         default:  push_step = 2'd0;
      endcase
   end

   exc_push_fmt #(.AW(AW), .DW(DW), .PC_W(PC_W)) u_push (
      .step_i(push_step), .pc_i(pc_s), .ccr_i(ccr_s), .exr_i(exr_s),
      .sp_i(sp_s), .addr_o(push_addr), .data_o(push_data)
   );

   exc_mask_upd #(.PRIO_W(PRIO_W)) u_mask (
      .icm2_i(icm_s), .ccr_i(ccr_s), .exr_i(exr_s),
      .ccr_o(ccr_nx), .exr_o(exr_nx)
   );

   exc_vec_join #(.DW(DW), .PC_W(PC_W)) u_join (
      .hi_i(vhi_q), .lo_i(rd_data_i), .pc_o(vec_pc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         pc_s  <= '0;
         ccr_s <= '0;
         exr_s <= '0;
         sp_s  <= '0;
         icm_s <= 1'b0;
         vhi_q <= '0;
         pc_q  <= '0;
         ccr_q <= '0;
         exr_q <= '0;
         sp_q  <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (trig_i) begin
               st_q  <= ST_PUSH0;
               pc_s  <= PC_W'(pc_i);
               ccr_s <= ccr_i;
               exr_s <= exr_i;
               sp_s  <= sp_i;
               icm_s <= icm2_i;
            end
            ST_PUSH0: st_q <= ST_PUSH1;
            ST_PUSH1: st_q <= ST_PUSH2;
            ST_PUSH2: st_q <= ST_MASK;
            ST_MASK: begin
               ccr_s <= ccr_nx;
               exr_s <= exr_nx;
               st_q  <= ST_RDHI;
            end
            ST_RDHI: st_q <= ST_RDLO;
            ST_RDLO: begin
               vhi_q <= rd_data_i;
               st_q  <= ST_LOAD;
            end
            ST_LOAD: begin
               pc_q  <= vec_pc;
               ccr_q <= ccr_s;
               exr_q <= exr_s;
               sp_q  <= sp_s - SP_DROP;
               st_q  <= ST_FIN;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign wr_en_o   = (st_q == ST_PUSH0) || (st_q == ST_PUSH1) || (st_q == ST_PUSH2);
   assign wr_addr_o = 24'(push_addr);
   assign wr_data_o = 16'(push_data);
   assign rd_en_o   = (st_q == ST_RDHI) || (st_q == ST_RDLO);
   assign rd_addr_o = 24'((st_q == ST_RDLO) ? VEC_LO : AW'(VEC_ADDR));
   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = (st_q == ST_FIN);
   assign pc_o      = 24'(pc_q);
   assign ccr_o     = ccr_q;
   assign exr_o     = exr_q;
   assign sp_o      = 24'(sp_q);

   AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_o && $past(wr_en_o)) |-> (wr_addr_o == $past(wr_addr_o) - 24'd2)); // R2
   AST_SP_FINAL: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> (sp_o == $past(wr_addr_o, 5))); // R3
   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> ccr_o[IMASK_BIT]); // R4
   AST_TRACE_CLR: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> !exr_o[TRACE_BIT]); // R5
   AST_VEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n) (rd_en_o && !$past(rd_en_o)) |=> (rd_en_o && rd_addr_o == $past(rd_addr_o) + 24'd2)); // R7
   AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !busy_o); // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R9
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
   localparam logic [23:0] VEC = 24'h000010;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_i = 1'b0;
   logic        icm2_i = 1'b0;
   logic [23:0] pc_i = '0;
   logic [7:0]  ccr_i = '0;
   logic [7:0]  exr_i = '0;
   logic [23:0] sp_i = '0;
   logic [15:0] rd_data_i = '0;
   logic        wr_en_o, rd_en_o, busy_o, done_o;
   logic [23:0] wr_addr_o, rd_addr_o, pc_o, sp_o;
   logic [15:0] wr_data_o;
   logic [7:0]  ccr_o, exr_o;

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;

   logic [15:0] vhi_m = 16'h0000;
   logic [15:0] vlo_m = 16'h0000;

   int          k = 0;
   logic [23:0] m_pc, m_sp;
   logic [7:0]  m_ccr, m_exr;
   logic        m_icm;
   logic [23:0] o_pc = '0, o_sp = '0;
   logic [7:0]  o_ccr = '0, o_exr = '0;

   always #2 clk = ~clk;

   exc_entry_seq #(.VEC_ADDR(VEC)) uut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .icm2_i(icm2_i),
      .pc_i(pc_i), .ccr_i(ccr_i), .exr_i(exr_i), .sp_i(sp_i),
      .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
      .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .ccr_o(ccr_o),
      .exr_o(exr_o), .sp_o(sp_o)
   );

   always @(posedge clk) begin
      if (rd_en_o) begin
         if (rd_addr_o == VEC) rd_data_i <= vhi_m;
         else if (rd_addr_o == VEC + 24'd2) rd_data_i <= vlo_m;
         else rd_data_i <= 16'hDEAD;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         k = 0;
         o_pc = '0; o_sp = '0; o_ccr = '0; o_exr = '0;
      end else if (k == 0) begin
         if (trig_i) begin
            k = 1;
            m_pc = pc_i; m_ccr = ccr_i; m_exr = exr_i; m_sp = sp_i; m_icm = icm2_i;
         end
      end else if (k == 8) begin
         k = 0;
      end else begin
         k = k + 1;
         if (k == 8) begin
            o_pc  = {vhi_m[7:0], vlo_m};
            o_ccr = m_ccr | 8'h80;
            o_exr = m_icm ? {1'b0, m_exr[6:3], 3'b111} : {1'b0, m_exr[6:0]};
            o_sp  = m_sp - 24'd6;
         end
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!busy_o && !done_o && !wr_en_o && !rd_en_o, "R10 ctl", {busy_o, done_o, wr_en_o, rd_en_o}, 0);
         chk(pc_o == 0 && sp_o == 0 && ccr_o == 0 && exr_o == 0, "R10 outs", pc_o, 0);
      end else begin
         chk(busy_o == (k != 0), "R1/R8 busy", busy_o, k != 0);
         chk(done_o == (k == 8), "R9 done", done_o, k == 8);
         chk(wr_en_o == (k >= 1 && k <= 3), "R2 wr_en", wr_en_o, (k >= 1 && k <= 3));
         if (k == 1) begin
            chk(wr_addr_o == m_sp - 24'd2, "R2 addr0", wr_addr_o, m_sp - 24'd2);
            chk(wr_data_o == m_pc[15:0], "R2 data0", wr_data_o, m_pc[15:0]);
         end
         if (k == 2) begin
            chk(wr_addr_o == m_sp - 24'd4, "R2 addr1", wr_addr_o, m_sp - 24'd4);
            chk(wr_data_o == {m_ccr, m_pc[23:16]}, "R2 data1", wr_data_o, {m_ccr, m_pc[23:16]});
         end
         if (k == 3) begin
            chk(wr_addr_o == m_sp - 24'd6, "R2 addr2", wr_addr_o, m_sp - 24'd6);
            chk(wr_data_o == {m_exr, 8'h00}, "R2 data2", wr_data_o, {m_exr, 8'h00});
         end
         chk(rd_en_o == (k == 5 || k == 6), "R7 rd_en", rd_en_o, (k == 5 || k == 6));
         if (k == 5) chk(rd_addr_o == VEC, "R7 addr hi", rd_addr_o, VEC);
         if (k == 6) chk(rd_addr_o == VEC + 24'd2, "R7 addr lo", rd_addr_o, VEC + 24'd2);
         chk(pc_o == o_pc, "R7 pc", pc_o, o_pc);
         chk(sp_o == o_sp, "R3 sp", sp_o, o_sp);
         chk(ccr_o == o_ccr, "R4 ccr", ccr_o, o_ccr);
         chk(exr_o == o_exr, "R5/R6 exr", exr_o, o_exr);
      end
   end

   task automatic fire(input logic [23:0] pc, input logic [7:0] ccr, input logic [7:0] exr,
                       input logic [23:0] sp, input logic icm, input logic [15:0] hi, input logic [15:0] lo);
      @(negedge clk);
      vhi_m = hi; vlo_m = lo;
      pc_i = pc; ccr_i = ccr; exr_i = exr; sp_i = sp; icm2_i = icm;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      pc_i = ~pc; ccr_i = ~ccr; exr_i = ~exr; sp_i = ~sp; icm2_i = ~icm;
      repeat (10) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 R4 R5 R6: mode 0, trace set, priority kept
      fire(24'h12ABCD, 8'h05, 8'h83, 24'h00FF00, 1'b0, 16'hAA34, 16'h5678);
      // R6: mode 2 priority forced to 7, R4 UI bit kept
      fire(24'hFEDCBA, 8'h40, 8'hC2, 24'h001000, 1'b1, 16'h0011, 16'h2233);
      // R4: mask already set
      fire(24'h000002, 8'hFF, 8'h00, 24'h000006, 1'b1, 16'hFF80, 16'h0000);
      // R8: retrigger while busy is ignored
      @(negedge clk);
      vhi_m = 16'h0001; vlo_m = 16'h0100;
      pc_i = 24'h001234; ccr_i = 8'h11; exr_i = 8'h22; sp_i = 24'h002000; icm2_i = 1'b0;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      repeat (2) @(negedge clk);
      pc_i = 24'h777777; ccr_i = 8'h00; exr_i = 8'hFF; sp_i = 24'h123456; icm2_i = 1'b1;
      trig_i = 1'b1;
      @(negedge clk);
      trig_i = 1'b0;
      repeat (10) @(negedge clk);
      // R1 R8: trigger held high, accepted again right after busy falls
      @(negedge clk);
      pc_i = 24'h0ABCDE; ccr_i = 8'h2A; exr_i = 8'h85; sp_i = 24'h00F000; icm2_i = 1'b1;
      trig_i = 1'b1;
      repeat (14) @(negedge clk);
      trig_i = 1'b0;
      repeat (12) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=5000", cyc);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule